// File: doc/BRIEF.md
# Directory Home Controller for Line Coherence

This block is the home agent for one slice of a distributed shared memory. Nodes send it read requests (for a shared copy) and read-exclusive requests (for a writable copy) of lines whose home field names this slice. For every line it keeps a coherence state and a holder vector with one bit per node. It also keeps the line's backing data.

When a request needs other caches to act, the controller issues one command. The command goes only to the nodes whose holder bit is set. It is either an invalidate or a fetch, which downgrades the owner to shared. The controller then waits until every one of those nodes has acknowledged. Only after the last acknowledgement does it update the directory and send the grant. Because each request is resolved in full before the next is taken, the controller is the single point that orders all writes to its lines.

Requests that arrive while a transaction is pending receive a busy refusal, and the requester retries later. Requests aimed at a different home receive an error refusal.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is invalid with an empty holder vector, and line `i` holds data value `i`. No grant, refusal or command is valid in the first cycle after reset.
- R2: The address is `{line index, home field}`, with the home field in the low `HOME_W` bits. A request whose home field differs from `HOME_ID` gets a refusal with kind 1 (bad home) to its source in the next cycle. It changes no directory state.
- R3: A read to an invalid or shared line is granted in the next cycle. The grant is shared (excl = 0) and carries the stored data. The requester's bit is added to the holders and the line becomes shared.
- R4: A read to a line modified by another node sends a fetch (kind 1) to the owner only. The owner's acknowledgement data is written to memory and returned in the grant. The line becomes shared, holding both the owner and the requester.
- R5: A read-exclusive sends an invalidate (kind 0) to every holder except the requester. The exclusive grant (excl = 1) appears in the cycle after the last acknowledgement. The line becomes modified with only the requester's bit set. With no other holders, the grant comes in the next cycle and no command is sent.
- R6: A read-exclusive to a line modified by another node invalidates that owner. The grant returns the data carried by the owner's acknowledgement.
- R7: A request that arrives while a transaction is pending is refused in the next cycle with kind 0 (busy), and it has no effect on any line. A bad home field takes precedence, giving kind 1.
- R8: Acknowledgements from nodes that are not being waited on are ignored. They neither shorten the wait nor supply data.
- R9: A request from the current owner of a modified line is granted in the next cycle with excl = 1 and the stored data. No command is sent and the state is unchanged.
- R10: A command is never sent to the requester or to a node without a holder bit. A fetch is always addressed to exactly one node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | NODE_W | Requesting node |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read |
| req_addr | input | LINE_W+HOME_W | Line index above home field |
| ack_valid | input | NODES | One acknowledgement bit per node |
| ack_data | input | DATA_W | Data carried by the owner's acknowledgement |
| cmd_valid | output | 1 | Coherence command pulse |
| cmd_kind | output | 1 | 0 = invalidate, 1 = fetch |
| cmd_mask | output | NODES | Target nodes of the command |
| cmd_line | output | LINE_W | Line the command concerns |
| gnt_valid | output | 1 | Grant pulse |
| gnt_dst | output | NODE_W | Node receiving the grant |
| gnt_excl | output | 1 | 1 = writable copy granted |
| gnt_data | output | DATA_W | Line data |
| nak_valid | output | 1 | Refusal pulse |
| nak_dst | output | NODE_W | Node receiving the refusal |
| nak_kind | output | 1 | 0 = busy, 1 = bad home |

## Verification
The bench builds the block with four nodes, sixteen lines, a two-bit home field and `HOME_ID` 1. Four nodes make it possible to have a holder vector with three sharers plus the requester, and an owner that is a different node from the requester. The responder acknowledges from node `i` after `i+1` cycles. The grant must therefore wait for the slowest holder, and there is room to inject busy requests and stray acknowledgements while the controller waits. With a two-bit home field, both a higher and a lower home value can be used as bad homes.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    localparam logic CMD_INV     = 1'b0;
    localparam logic CMD_FETCH   = 1'b1;
    localparam logic NAK_BUSY    = 1'b0;
    localparam logic NAK_BADHOME = 1'b1;

endpackage

// File: rtl/dir_addr_split.sv
module dir_addr_split #(
    parameter int LINE_W  = 4,
    parameter int HOME_W  = 2,
    parameter int HOME_ID = 1
) (
    input  logic [LINE_W+HOME_W-1:0] addr,
    output logic [LINE_W-1:0]        line,
    output logic                     home_ok
);
    // home field sits below the line index
    assign line    = addr[LINE_W+HOME_W-1:HOME_W];
    assign home_ok = (addr[HOME_W-1:0] == HOME_W'(HOME_ID));
endmodule

// File: rtl/dir_target_sel.sv
module dir_target_sel
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int NODE_W = 2
) (
    input  line_st_e          st,
    input  logic [NODES-1:0]  holders,
    input  logic [NODE_W-1:0] src,
    input  logic              excl,
    output logic [NODES-1:0]  targets,
    output logic              kind
);
    logic [NODES-1:0] others;

    assign others = holders & ~(NODES'(1) << src);

    always_comb begin
        targets = '0;
        kind    = CMD_INV;
        case (st)
            LS_S: begin
                if (excl) targets = others;
            end
            LS_M: begin
                targets = others;
                kind    = excl ? CMD_INV : CMD_FETCH;
            end
            default: begin
                targets = '0;
            end
        endcase
    end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int LINES   = 16,
    parameter int HOME_W  = 2,
    parameter int DATA_W  = 8,
    parameter int HOME_ID = 1,
    localparam int NODE_W = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES),
    localparam int ADDR_W = LINE_W + HOME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NODE_W-1:0] req_src,
    input  logic              req_excl,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NODES-1:0]  ack_valid,
    input  logic [DATA_W-1:0] ack_data,
    output logic              cmd_valid,
    output logic              cmd_kind,
    output logic [NODES-1:0]  cmd_mask,
    output logic [LINE_W-1:0] cmd_line,
    output logic              gnt_valid,
    output logic [NODE_W-1:0] gnt_dst,
    output logic              gnt_excl,
    output logic [DATA_W-1:0] gnt_data,
    output logic              nak_valid,
    output logic [NODE_W-1:0] nak_dst,
    output logic              nak_kind
);

    typedef struct packed {
        phase_e            phase;
        logic [NODES-1:0]  pend;
        logic [LINE_W-1:0] line;
        logic [NODE_W-1:0] src;
        logic              excl;
        logic              was_m;
        logic              gnt_v;
        logic [NODE_W-1:0] gnt_dst;
        logic              gnt_x;
        logic [DATA_W-1:0] gnt_d;
        logic              nak_v;
        logic [NODE_W-1:0] nak_dst;
        logic              nak_k;
        logic              cmd_v;
        logic              cmd_k;
        logic [NODES-1:0]  cmd_m;
        logic [LINE_W-1:0] cmd_l;
    } ctl_t;

    ctl_t              c_q, c_d;
    line_st_e          st_q  [LINES];
    line_st_e          st_d  [LINES];
    logic [NODES-1:0]  vec_q [LINES];
    logic [NODES-1:0]  vec_d [LINES];
    logic [DATA_W-1:0] mem_q [LINES];
    logic [DATA_W-1:0] mem_d [LINES];

    logic [LINE_W-1:0] req_line;
    logic              home_ok;
    logic [NODES-1:0]  tgt_mask;
    logic              tgt_kind;
    logic [NODES-1:0]  src_bit;
    logic [NODES-1:0]  owner_bit;
    logic [NODES-1:0]  pend_left;
    logic              pend_hit;

    dir_addr_split #(
        .LINE_W (LINE_W),
        .HOME_W (HOME_W),
        .HOME_ID(HOME_ID)
    ) split_i (
        .addr   (req_addr),
        .line   (req_line),
        .home_ok(home_ok)
    );

    dir_target_sel #(
        .NODES (NODES),
        .NODE_W(NODE_W)
    ) tsel_i (
        .st     (st_q[req_line]),
        .holders(vec_q[req_line]),
        .src    (req_src),
        .excl   (req_excl),
        .targets(tgt_mask),
        .kind   (tgt_kind)
    );

    assign src_bit   = NODES'(1) << req_src;
    assign owner_bit = NODES'(1) << c_q.src;
    assign pend_left = c_q.pend & ~ack_valid;
    assign pend_hit  = |(c_q.pend & ack_valid);

    always_comb begin
        c_d       = c_q;
        st_d      = st_q;
        vec_d     = vec_q;
        mem_d     = mem_q;
        c_d.gnt_v = 1'b0;
        c_d.nak_v = 1'b0;
        c_d.cmd_v = 1'b0;

        if (c_q.phase == PH_WAIT) begin
            // only acknowledgements from awaited nodes count
            c_d.pend = pend_left;
            if (c_q.was_m && pend_hit) mem_d[c_q.line] = ack_data;
            if (pend_left == '0) begin
                c_d.phase   = PH_IDLE;
                c_d.gnt_v   = 1'b1;
                c_d.gnt_dst = c_q.src;
                c_d.gnt_x   = c_q.excl;
                c_d.gnt_d   = mem_d[c_q.line];
                if (c_q.excl) begin
                    st_d[c_q.line]  = LS_M;
                    vec_d[c_q.line] = owner_bit;
                end else begin
                    st_d[c_q.line]  = LS_S;
                    vec_d[c_q.line] = vec_q[c_q.line] | owner_bit;
                end
            end
            if (req_valid) begin
                c_d.nak_v   = 1'b1;
                c_d.nak_dst = req_src;
                c_d.nak_k   = home_ok ? NAK_BUSY : NAK_BADHOME;
            end
        end else if (req_valid) begin
            if (!home_ok) begin
                c_d.nak_v   = 1'b1;
                c_d.nak_dst = req_src;
                c_d.nak_k   = NAK_BADHOME;
            end else if (tgt_mask == '0) begin
                c_d.gnt_v   = 1'b1;
                c_d.gnt_dst = req_src;
                c_d.gnt_d   = mem_q[req_line];
                if (st_q[req_line] == LS_M) begin
                    c_d.gnt_x = 1'b1;
                end else if (req_excl) begin
                    c_d.gnt_x       = 1'b1;
                    st_d[req_line]  = LS_M;
                    vec_d[req_line] = src_bit;
                end else begin
                    c_d.gnt_x       = 1'b0;
                    st_d[req_line]  = LS_S;
                    vec_d[req_line] = vec_q[req_line] | src_bit;
                end
            end else begin
                c_d.cmd_v = 1'b1;
                c_d.cmd_k = tgt_kind;
                c_d.cmd_m = tgt_mask;
                c_d.cmd_l = req_line;
                c_d.phase = PH_WAIT;
                c_d.pend  = tgt_mask;
                c_d.line  = req_line;
                c_d.src   = req_src;
                c_d.excl  = req_excl;
                c_d.was_m = (st_q[req_line] == LS_M);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LS_I;
                vec_q[i] <= '0;
                mem_q[i] <= DATA_W'(i);
            end
        end else begin
            c_q   <= c_d;
            st_q  <= st_d;
            vec_q <= vec_d;
            mem_q <= mem_d;
        end
    end

    assign cmd_valid = c_q.cmd_v;
    assign cmd_kind  = c_q.cmd_k;
    assign cmd_mask  = c_q.cmd_m;
    assign cmd_line  = c_q.cmd_l;
    assign gnt_valid = c_q.gnt_v;
    assign gnt_dst   = c_q.gnt_dst;
    assign gnt_excl  = c_q.gnt_x;
    assign gnt_data  = c_q.gnt_d;
    assign nak_valid = c_q.nak_v;
    assign nak_dst   = c_q.nak_dst;
    assign nak_kind  = c_q.nak_k;

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
    parameter int NODES   = 4,
    parameter int NODE_W  = 2,
    parameter int HOME_W  = 2,
    parameter int HOME_ID = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [NODE_W-1:0] req_src,
    input logic [HOME_W-1:0] req_home,
    input logic [NODES-1:0]  ack_valid,
    input logic              cmd_valid,
    input logic              cmd_kind,
    input logic [NODES-1:0]  cmd_mask,
    input logic              gnt_valid,
    input logic              nak_valid,
    input logic              nak_kind
);
    logic [NODES-1:0] await_q;
    logic             open_q;
    logic             waiting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            await_q <= '0;
            open_q  <= 1'b0;
        end else begin
            await_q <= cmd_valid ? cmd_mask : (await_q & ~ack_valid);
            if (cmd_valid)      open_q <= 1'b1;
            else if (gnt_valid) open_q <= 1'b0;
        end
    end

    assign waiting = cmd_valid || (open_q && !gnt_valid);

    // R2
    bad_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_home != HOME_W'(HOME_ID)) |=> (nak_valid && nak_kind));

    // R7
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && waiting) |=> nak_valid);

    // R5
    acks_before_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (await_q == '0));

    // R10
    cmd_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_mask != '0));

    // R10
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind) |-> $onehot(cmd_mask));

    // R10
    cmd_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cmd_mask[$past(req_src)]);

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
    .NODES  (NODES),
    .NODE_W (NODE_W),
    .HOME_W (HOME_W),
    .HOME_ID(HOME_ID)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_src  (req_src),
    .req_home (req_addr[HOME_W-1:0]),
    .ack_valid(ack_valid),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_mask (cmd_mask),
    .gnt_valid(gnt_valid),
    .nak_valid(nak_valid),
    .nak_kind (nak_kind)
);

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NODES   = 4;
    localparam int LINES   = 16;
    localparam int HOME_W  = 2;
    localparam int DATA_W  = 8;
    localparam int HOME_ID = 1;
    localparam int NODE_W  = $clog2(NODES);
    localparam int LINE_W  = $clog2(LINES);
    localparam int ADDR_W  = LINE_W + HOME_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              req_valid = 1'b0;
    logic [NODE_W-1:0] req_src = '0;
    logic              req_excl = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [NODES-1:0]  resp_ack = '0;
    logic [NODES-1:0]  stray_ack = '0;
    logic [NODES-1:0]  ack_valid;
    logic [DATA_W-1:0] ack_data = '0;
    logic              cmd_valid, cmd_kind, gnt_valid, gnt_excl, nak_valid, nak_kind;
    logic [NODES-1:0]  cmd_mask;
    logic [LINE_W-1:0] cmd_line;
    logic [NODE_W-1:0] gnt_dst, nak_dst;
    logic [DATA_W-1:0] gnt_data;

    assign ack_valid = resp_ack | stray_ack;

    dir_home_ctrl #(
        .NODES(NODES), .LINES(LINES), .HOME_W(HOME_W), .DATA_W(DATA_W), .HOME_ID(HOME_ID)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_excl(req_excl), .req_addr(req_addr),
        .ack_valid(ack_valid), .ack_data(ack_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_mask(cmd_mask), .cmd_line(cmd_line),
        .gnt_valid(gnt_valid), .gnt_dst(gnt_dst), .gnt_excl(gnt_excl), .gnt_data(gnt_data),
        .nak_valid(nak_valid), .nak_dst(nak_dst), .nak_kind(nak_kind)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    model_on = 1'b0;
    string cur_req = "R1";

    function automatic logic [7:0] odata(int n, int l);
        return 8'(((n * 16) + l) ^ 8'h5A);
    endfunction

    function automatic int pack_gnt(bit v, int dst, bit x, int d);
        return (int'(v) << 11) | ((dst & 3) << 9) | (int'(x) << 8) | (d & 8'hFF);
    endfunction

    function automatic int pack_nak(bit v, int dst, bit k);
        return (int'(v) << 3) | ((dst & 3) << 1) | int'(k);
    endfunction

    function automatic int pack_cmd(bit v, bit k, int m, int l);
        return (int'(v) << 9) | (int'(k) << 8) | ((m & 15) << 4) | (l & 15);
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // reference model: behavioural directory and expected outputs
    int               m_st  [LINES];
    bit [NODES-1:0]   m_vec [LINES];
    int               m_mem [LINES];
    bit               m_wait;
    bit [NODES-1:0]   m_pend;
    int               m_line, m_src, m_l, m_h;
    bit               m_excl, m_wasm;
    bit [NODES-1:0]   m_need, m_me;
    bit               e_gv, e_gx, e_nv, e_nk, e_cv, e_ck;
    int               e_gdst, e_gd, e_ndst, e_cm, e_cl;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                m_st[i] = 0; m_vec[i] = '0; m_mem[i] = i;
            end
            m_wait = 0; m_pend = '0;
            e_gv = 0; e_nv = 0; e_cv = 0;
            e_gdst = 0; e_gx = 0; e_gd = 0; e_ndst = 0; e_nk = 0; e_ck = 0; e_cm = 0; e_cl = 0;
        end else begin
            e_gv = 0; e_nv = 0; e_cv = 0;
            if (m_wait) begin
                if (m_wasm && ((m_pend & ack_valid) != 0)) m_mem[m_line] = ack_data;
                m_pend = m_pend & ~ack_valid;
                if (m_pend == 0) begin
                    m_wait = 0;
                    e_gv = 1; e_gdst = m_src; e_gx = m_excl; e_gd = m_mem[m_line];
                    m_me = NODES'(1) << m_src;
                    if (m_excl) begin m_st[m_line] = 2; m_vec[m_line] = m_me; end
                    else begin m_st[m_line] = 1; m_vec[m_line] = m_vec[m_line] | m_me; end
                end
                if (req_valid) begin
                    e_nv = 1; e_ndst = req_src;
                    e_nk = (int'(req_addr) % (1 << HOME_W)) != HOME_ID;
                end
            end else if (req_valid) begin
                m_l = int'(req_addr) >> HOME_W;
                m_h = int'(req_addr) % (1 << HOME_W);
                m_me = NODES'(1) << req_src;
                if (m_h != HOME_ID) begin
                    e_nv = 1; e_ndst = req_src; e_nk = 1;
                end else begin
                    m_need = '0;
                    if (m_st[m_l] == 2 || (m_st[m_l] == 1 && req_excl))
                        m_need = m_vec[m_l] & ~m_me;
                    if (m_need == 0) begin
                        e_gv = 1; e_gdst = req_src; e_gd = m_mem[m_l];
                        if (m_st[m_l] == 2) e_gx = 1;
                        else if (req_excl) begin e_gx = 1; m_st[m_l] = 2; m_vec[m_l] = m_me; end
                        else begin e_gx = 0; m_st[m_l] = 1; m_vec[m_l] = m_vec[m_l] | m_me; end
                    end else begin
                        e_cv = 1; e_cm = m_need; e_cl = m_l;
                        e_ck = (m_st[m_l] == 2) && !req_excl;
                        m_wait = 1; m_pend = m_need; m_line = m_l; m_src = req_src;
                        m_excl = req_excl; m_wasm = (m_st[m_l] == 2);
                    end
                end
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            if (gnt_valid || e_gv)
                check_eq(cur_req, "model grant",
                         pack_gnt(gnt_valid, gnt_dst, gnt_excl, gnt_data),
                         pack_gnt(e_gv, e_gdst, e_gx, e_gd));
            if (nak_valid || e_nv)
                check_eq(cur_req, "model refusal",
                         pack_nak(nak_valid, nak_dst, nak_kind), pack_nak(e_nv, e_ndst, e_nk));
            if (cmd_valid || e_cv)
                check_eq(cur_req, "model command",
                         pack_cmd(cmd_valid, cmd_kind, cmd_mask, cmd_line),
                         pack_cmd(e_cv, e_ck, e_cm, e_cl));
        end
    end

    // remote cache responder: node i answers i+1 cycles after its command
    int cnt [NODES];
    int cl  [NODES];
    always @(negedge clk) begin
        if (!rst_n) begin
            resp_ack = '0;
            for (int i = 0; i < NODES; i++) begin cnt[i] = 0; cl[i] = 0; end
        end else begin
            resp_ack = '0;
            for (int i = 0; i < NODES; i++) begin
                if (cnt[i] > 0) begin
                    cnt[i]--;
                    if (cnt[i] == 0) begin
                        resp_ack[i] = 1'b1;
                        ack_data = odata(i, cl[i]);
                    end
                end
            end
            if (cmd_valid)
                for (int i = 0; i < NODES; i++)
                    if (cmd_mask[i]) begin cnt[i] = i + 1; cl[i] = int'(cmd_line); end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL all-requirements watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    task automatic send(int src, bit x, int line, int home);
        @(negedge clk);
        req_valid = 1'b1;
        req_src   = NODE_W'(src);
        req_excl  = x;
        req_addr  = ADDR_W'((line << HOME_W) | home);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_gnt(string req, int dst, bit x, int d);
        for (int n = 0; n < 40 && !gnt_valid; n++) @(negedge clk);
        check_eq(req, "grant", pack_gnt(gnt_valid, gnt_dst, gnt_excl, gnt_data), pack_gnt(1, dst, x, d));
    endtask

    task automatic wait_cmd(string req, int m, bit k, int l);
        for (int n = 0; n < 40 && !cmd_valid; n++) @(negedge clk);
        check_eq(req, "command", pack_cmd(cmd_valid, cmd_kind, cmd_mask, cmd_line), pack_cmd(1, k, m, l));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check_eq("R1", "outputs after reset", {gnt_valid, nak_valid, cmd_valid}, 0);
        model_on = 1'b1;

        cur_req = "R3";
        send(0, 0, 2, HOME_ID);
        wait_gnt("R1", 0, 0, 2);
        send(1, 0, 2, HOME_ID);
        check_eq("R3", "no command for shared read", cmd_valid, 0);
        wait_gnt("R3", 1, 0, 2);

        cur_req = "R5";
        send(2, 1, 2, HOME_ID);
        wait_cmd("R5", 4'b0011, 0, 2);
        send(3, 0, 5, HOME_ID);
        check_eq("R7", "busy refusal", pack_nak(nak_valid, nak_dst, nak_kind), pack_nak(1, 3, 0));
        wait_gnt("R5", 2, 1, 2);
        cur_req = "R7";
        send(0, 1, 5, HOME_ID);
        check_eq("R7", "refused request left no holder", cmd_valid, 0);
        wait_gnt("R7", 0, 1, 5);

        cur_req = "R4";
        send(3, 0, 2, HOME_ID);
        wait_cmd("R4", 4'b0100, 1, 2);
        wait_gnt("R4", 3, 0, odata(2, 2));
        send(0, 0, 2, HOME_ID);
        wait_gnt("R4", 0, 0, odata(2, 2));

        cur_req = "R6";
        send(1, 1, 7, HOME_ID);
        check_eq("R5", "no command without other holders", cmd_valid, 0);
        wait_gnt("R5", 1, 1, 7);
        send(3, 1, 7, HOME_ID);
        wait_cmd("R6", 4'b0010, 0, 7);
        wait_gnt("R6", 3, 1, odata(1, 7));

        cur_req = "R9";
        send(3, 0, 7, HOME_ID);
        check_eq("R9", "owner read sends nothing", cmd_valid, 0);
        wait_gnt("R9", 3, 1, odata(1, 7));
        send(3, 1, 7, HOME_ID);
        wait_gnt("R9", 3, 1, odata(1, 7));

        cur_req = "R2";
        send(1, 1, 2, 2);
        check_eq("R2", "bad home high", pack_nak(nak_valid, nak_dst, nak_kind), pack_nak(1, 1, 1));
        send(1, 1, 2, 0);
        check_eq("R2", "bad home low", pack_nak(nak_valid, nak_dst, nak_kind), pack_nak(1, 1, 1));
        send(1, 0, 2, HOME_ID);
        check_eq("R2", "bad home left line unchanged", cmd_valid, 0);
        wait_gnt("R3", 1, 0, odata(2, 2));
        cur_req = "R10";
        send(1, 1, 2, HOME_ID);
        wait_cmd("R10", 4'b1101, 0, 2);
        wait_gnt("R10", 1, 1, odata(2, 2));

        cur_req = "R8";
        send(3, 1, 9, HOME_ID);
        wait_gnt("R8", 3, 1, 9);
        send(0, 0, 9, HOME_ID);
        wait_cmd("R10", 4'b1000, 1, 9);
        @(negedge clk);
        stray_ack = 4'b0011;
        @(negedge clk);
        stray_ack = '0;
        check_eq("R8", "stray ack gives no grant", gnt_valid, 0);
        @(negedge clk);
        check_eq("R8", "still waiting for owner", gnt_valid, 0);
        wait_gnt("R8", 0, 0, odata(3, 9));

        cur_req = "R7";
        send(2, 1, 9, HOME_ID);
        wait_cmd("R5", 4'b1001, 0, 9);
        send(1, 0, 4, 3);
        check_eq("R7", "bad home wins over busy", pack_nak(nak_valid, nak_dst, nak_kind), pack_nak(1, 1, 1));
        wait_gnt("R5", 2, 1, odata(3, 9));

        repeat (8) @(negedge clk);
        finish_run();
    end
endmodule